// File: doc/BRIEF.md
# Multi-Initiator Backplane Bus Fabric

This block joins several bus initiators and several targets on a shared backplane without tri-state drivers. It is built as a set of multiplexers. The initiators are a CPU, a console and a configurable number of IO bridges. The targets are a memory controller, the console and the same IO bridges. Address and write data travel on separate buses. The address word holds control flags in its upper bits and the location in its lower bits. The data path is 36 bits wide.

Arbitration is repeated on every clock and nothing is locked between cycles. The winner's address and write data are registered onto the target side for exactly one cycle. Every target sees that cycle. The fabric picks the read data and acknowledge from whichever target answered and registers them back to the initiator that won. When no target answers, the initiator is told so. Interrupt-identification reads are marked by one flag bit in the address word. Several bridges may answer the same such read, and the fabric keeps only the answer from the lowest-numbered bridge. The fabric also combines the seven-level interrupt requests of all bridges into a single vector for the CPU.

The request side uses a valid/ready handshake. An initiator raises `ini_valid` and holds its address and write data steady until its `ini_ready` bit is high for one clock. That clock is the transfer, and the initiator drops or changes its request after it. `ini_ready` is never high before the request has been sampled, so the wait is always at least one cycle. The response side has no back-pressure. `ini_rsp_valid` is a one-clock strobe that the initiator must take when it comes. Targets answer combinationally within the cycle in which `tgt_valid` is high.

Top module: `bp_fabric`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ini_ready`, `tgt_valid` and `ini_rsp_valid` are all zero.
- R2: At most one bit of `ini_ready` is high in any cycle. A bit goes high only in the cycle after an edge at which the same initiator's `ini_valid` was sampled high.
- R3: Fixed priority between classes: any IO bridge (initiator index 2 and up) beats the console (index 1), and the console beats the CPU (index 0).
- R4: Among requesting IO bridges, the lowest bridge number (lowest initiator index) wins.
- R5: A grant lasts exactly one clock. An initiator granted in one cycle is not granted in the next, so another requester, if any, gets that cycle. Arbitration starts afresh on every clock.
- R6: `tgt_valid` is high in exactly the cycles in which some `ini_ready` bit is high. In those cycles `tgt_addr` and `tgt_wdata` equal the granted initiator's `ini_addr` and `ini_wdata` slices.
- R7: One cycle after a grant, `ini_rsp_valid` is high for the same initiator only. `ini_rsp_data` carries the read data of the acknowledging target chosen in this order: bridges by ascending number (target index 2 and up), then the console (target index 1), then memory (target index 0).
- R8: If no eligible target acknowledges the grant cycle, the response carries data zero with `ini_rsp_nak` high. Otherwise `ini_rsp_nak` is low.
- R9: When address bit `WRU_BIT` (default 27) is set in the grant cycle, the cycle is an interrupt-identification read. Only bridge acknowledges count, so acks from the console or memory are ignored, and the lowest-numbered acknowledging bridge supplies the data.
- R10: `cpu_irq[k]` is the OR of level k across all bridges, with bridge b's levels at `br_irq[7*b +: 7]`. It follows the inputs with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ini_valid | input | NI (5) | Request valid per initiator: 0 CPU, 1 console, 2+ bridges |
| ini_ready | output | NI (5) | One-hot grant; the transfer cycle |
| ini_addr | input | NI*AW (180) | Address words, flags in upper bits, initiator i at [AW*i +: AW] |
| ini_wdata | input | NI*DW (180) | Write data, initiator i at [DW*i +: DW] |
| ini_rsp_valid | output | NI (5) | Response strobe to the initiator granted one cycle before |
| ini_rsp_data | output | DW (36) | Selected read data, zero on no-acknowledge |
| ini_rsp_nak | output | 1 | No eligible target acknowledged |
| tgt_valid | output | 1 | Bus cycle present for all targets |
| tgt_addr | output | AW (36) | Routed address word |
| tgt_wdata | output | DW (36) | Routed write data |
| tgt_ack | input | NT (5) | Per-target acknowledge: 0 memory, 1 console, 2+ bridges |
| tgt_rdata | input | NT*DW (180) | Read data, target t at [DW*t +: DW] |
| br_irq | input | NB*7 (21) | Interrupt levels per bridge |
| cpu_irq | output | 7 | Merged interrupt levels |

## Verification
A request set up before edge n shows up as an `ini_ready` grant and a target-side cycle from edge n. The registered response to that grant appears from edge n+1. The merged interrupt vector settles within the same cycle as its inputs. The bench drives and samples on falling edges only. Each check is placed in the half-cycle just after the edge that must have produced its result, so the registered grant and response stages are each counted exactly once.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned BP_IRQ_LVLS  = 7;
  localparam int unsigned BP_FIXED_NUM = 2;
  // initiator slots
  localparam int unsigned INI_CPU = 0;
  localparam int unsigned INI_CON = 1;
  localparam int unsigned INI_BR0 = 2;
  // target slots
  localparam int unsigned TGT_MEM = 0;
  localparam int unsigned TGT_CON = 1;
  localparam int unsigned TGT_BR0 = 2;
endpackage

// File: rtl/bp_grant_arb.sv
module bp_grant_arb #(
  parameter int unsigned NB = 3,
  localparam int unsigned NI = NB + bp_pkg::BP_FIXED_NUM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NI-1:0] req,
  output logic [NI-1:0] grant_d,
  output logic [NI-1:0] grant_q
);
  import bp_pkg::*;

  logic [NI-1:0] live;
  logic          found;

  // an initiator holding grant now has its request consumed this cycle
  assign live = req & ~grant_q;

  always_comb begin
    grant_d = '0;
    found   = 1'b0;
    for (int b = 0; b < int'(NB); b++) begin
      if (!found && live[INI_BR0 + b]) begin
        grant_d[INI_BR0 + b] = 1'b1;
        found = 1'b1;
      end
    end
    if (!found && live[INI_CON]) begin
      grant_d[INI_CON] = 1'b1;
      found = 1'b1;
    end
    if (!found && live[INI_CPU]) begin
      grant_d[INI_CPU] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end
endmodule

// File: rtl/bp_route.sv
module bp_route #(
  parameter int unsigned NI = 5,
  parameter int unsigned AW = 36,
  parameter int unsigned DW = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NI-1:0]    sel,
  input  logic [NI*AW-1:0] addr_in,
  input  logic [NI*DW-1:0] data_in,
  output logic             valid_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    data_q
);
  logic [AW-1:0] addr_mux;
  logic [DW-1:0] data_mux;

  // AND-OR mux; sel is one-hot or empty
  always_comb begin
    addr_mux = '0;
    data_mux = '0;
    for (int i = 0; i < int'(NI); i++) begin
      addr_mux = addr_mux | (addr_in[AW*i +: AW] & {AW{sel[i]}});
      data_mux = data_mux | (data_in[DW*i +: DW] & {DW{sel[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= |sel;
      addr_q  <= addr_mux;
      data_q  <= data_mux;
    end
  end
endmodule

// File: rtl/bp_resp_sel.sv
module bp_resp_sel #(
  parameter int unsigned NB = 3,
  parameter int unsigned DW = 36,
  localparam int unsigned NT = NB + bp_pkg::BP_FIXED_NUM,
  localparam int unsigned NI = NB + bp_pkg::BP_FIXED_NUM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NI-1:0]    grant_q,
  input  logic             wru,
  input  logic [NT-1:0]    ack,
  input  logic [NT*DW-1:0] rdata,
  output logic [NI-1:0]    rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_nak
);
  import bp_pkg::*;

  logic [NT-1:0] elig;
  logic [NT-1:0] pick;
  logic          hit;
  logic [DW-1:0] data_mux;

  // identification reads accept bridge answers only
  always_comb begin
    elig = ack;
    if (wru) begin
      elig[TGT_MEM] = 1'b0;
      elig[TGT_CON] = 1'b0;
    end
  end

  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int b = 0; b < int'(NB); b++) begin
      if (!hit && elig[TGT_BR0 + b]) begin
        pick[TGT_BR0 + b] = 1'b1;
        hit = 1'b1;
      end
    end
    if (!hit && elig[TGT_CON]) begin
      pick[TGT_CON] = 1'b1;
      hit = 1'b1;
    end
    if (!hit && elig[TGT_MEM]) begin
      pick[TGT_MEM] = 1'b1;
      hit = 1'b1;
    end
  end

  always_comb begin
    data_mux = '0;
    for (int t = 0; t < int'(NT); t++)
      data_mux = data_mux | (rdata[DW*t +: DW] & {DW{pick[t]}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
      rsp_nak   <= 1'b0;
    end else begin
      rsp_valid <= grant_q;
      rsp_data  <= (|grant_q) ? data_mux : '0;
      rsp_nak   <= (|grant_q) & ~hit;
    end
  end
endmodule

// File: rtl/bp_irq_merge.sv
module bp_irq_merge #(
  parameter int unsigned NB = 3,
  parameter int unsigned NL = 7
) (
  input  logic [NB*NL-1:0] irq_in,
  output logic [NL-1:0]    irq_out
);
  always_comb begin
    irq_out = '0;
    for (int b = 0; b < int'(NB); b++)
      irq_out = irq_out | irq_in[NL*b +: NL];
  end
endmodule

// File: rtl/bp_fabric.sv
module bp_fabric #(
  parameter int unsigned NB      = 3,
  parameter int unsigned AW      = 36,
  parameter int unsigned DW      = 36,
  parameter int unsigned WRU_BIT = 27,
  localparam int unsigned NI = NB + bp_pkg::BP_FIXED_NUM,
  localparam int unsigned NT = NB + bp_pkg::BP_FIXED_NUM,
  localparam int unsigned NL = bp_pkg::BP_IRQ_LVLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NI-1:0]    ini_valid,
  output logic [NI-1:0]    ini_ready,
  input  logic [NI*AW-1:0] ini_addr,
  input  logic [NI*DW-1:0] ini_wdata,
  output logic [NI-1:0]    ini_rsp_valid,
  output logic [DW-1:0]    ini_rsp_data,
  output logic             ini_rsp_nak,
  output logic             tgt_valid,
  output logic [AW-1:0]    tgt_addr,
  output logic [DW-1:0]    tgt_wdata,
  input  logic [NT-1:0]    tgt_ack,
  input  logic [NT*DW-1:0] tgt_rdata,
  input  logic [NB*NL-1:0] br_irq,
  output logic [NL-1:0]    cpu_irq
);
  logic [NI-1:0] grant_d;
  logic [NI-1:0] grant_q;

  bp_grant_arb #(.NB(NB)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(ini_valid),
    .grant_d(grant_d), .grant_q(grant_q)
  );

  bp_route #(.NI(NI), .AW(AW), .DW(DW)) u_route (
    .clk(clk), .rst_n(rst_n), .sel(grant_d),
    .addr_in(ini_addr), .data_in(ini_wdata),
    .valid_q(tgt_valid), .addr_q(tgt_addr), .data_q(tgt_wdata)
  );

  bp_resp_sel #(.NB(NB), .DW(DW)) u_resp (
    .clk(clk), .rst_n(rst_n), .grant_q(grant_q),
    .wru(tgt_addr[WRU_BIT]), .ack(tgt_ack), .rdata(tgt_rdata),
    .rsp_valid(ini_rsp_valid), .rsp_data(ini_rsp_data), .rsp_nak(ini_rsp_nak)
  );

  bp_irq_merge #(.NB(NB), .NL(NL)) u_irq (
    .irq_in(br_irq), .irq_out(cpu_irq)
  );

  assign ini_ready = grant_q;
endmodule

// File: rtl/bp_fabric_chk.sv
module bp_fabric_chk #(
  parameter int unsigned NI = 5,
  parameter int unsigned DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NI-1:0] ini_valid,
  input logic [NI-1:0] ini_ready,
  input logic [NI-1:0] ini_rsp_valid,
  input logic [DW-1:0] ini_rsp_data,
  input logic          ini_rsp_nak,
  input logic          tgt_valid
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ini_ready)); // R2

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_ready != '0) |=> ((ini_ready & $past(ini_ready)) == '0)); // R5

  AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_ready != '0) |-> ((ini_ready & $past(ini_valid)) == ini_ready)); // R2

  AST_TGT_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid == (ini_ready != '0)); // R6

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_ready != '0) |=> (ini_rsp_valid == $past(ini_ready))); // R7

  AST_NAK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ini_rsp_nak |-> (ini_rsp_data == '0 && ini_rsp_valid != '0)); // R8
endmodule

bind bp_fabric bp_fabric_chk #(.NI(NI), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ini_valid(ini_valid), .ini_ready(ini_ready),
  .ini_rsp_valid(ini_rsp_valid), .ini_rsp_data(ini_rsp_data),
  .ini_rsp_nak(ini_rsp_nak), .tgt_valid(tgt_valid)
);

// File: tb/bp_fabric_tb.sv
module bp_fabric_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int AW = 36;
  localparam int DW = 36;
  localparam int WRU_BIT = 27;
  localparam int NI = NB + 2;
  localparam int NT = NB + 2;
  localparam int NL = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NI-1:0]    ini_valid;
  logic [NI-1:0]    ini_ready;
  logic [NI*AW-1:0] ini_addr;
  logic [NI*DW-1:0] ini_wdata;
  logic [NI-1:0]    ini_rsp_valid;
  logic [DW-1:0]    ini_rsp_data;
  logic             ini_rsp_nak;
  logic             tgt_valid;
  logic [AW-1:0]    tgt_addr;
  logic [DW-1:0]    tgt_wdata;
  logic [NT-1:0]    tgt_ack;
  logic [NT*DW-1:0] tgt_rdata;
  logic [NB*NL-1:0] br_irq;
  logic [NL-1:0]    cpu_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_fabric #(.NB(NB), .AW(AW), .DW(DW), .WRU_BIT(WRU_BIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .ini_valid(ini_valid), .ini_ready(ini_ready),
    .ini_addr(ini_addr), .ini_wdata(ini_wdata), .ini_rsp_valid(ini_rsp_valid),
    .ini_rsp_data(ini_rsp_data), .ini_rsp_nak(ini_rsp_nak),
    .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata), .br_irq(br_irq), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NI-1:0] exp_winner(input logic [NI-1:0] p);
    logic [NI-1:0] w = '0;
    for (int b = 0; b < NB; b++)
      if (p[2+b]) begin w[2+b] = 1'b1; return w; end
    if (p[1]) w[1] = 1'b1;
    else if (p[0]) w[0] = 1'b1;
    return w;
  endfunction

  function automatic logic [AW-1:0] addr_of(input int i);
    return AW'(36'h0_0000_1000) + AW'(i * 36'h0_0101_0011);
  endfunction

  function automatic logic [DW-1:0] rd_of(input int t);
    return DW'(36'h5_0000_0000) | DW'((t + 1) * 36'h0_0011_1111);
  endfunction

  task automatic reset_inputs();
    ini_valid = '0;
    tgt_ack   = '0;
    br_irq    = '0;
    for (int i = 0; i < NI; i++) begin
      ini_addr[AW*i +: AW]  = addr_of(i);
      ini_wdata[DW*i +: DW] = DW'(36'h7_0000_0000) | DW'(i * 36'h0_0000_00AB);
    end
    for (int t = 0; t < NT; t++) tgt_rdata[DW*t +: DW] = rd_of(t);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    reset_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 64'(ini_ready), 64'(0));
    chk("R1 tgt_valid in reset", 64'(tgt_valid), 64'(0));
    chk("R1 rsp_valid in reset", 64'(ini_rsp_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(ini_ready), 64'(0));

    // grant sweep over every request pattern: R2 R3 R4 R6 R7
    for (int p = 1; p < (1 << NI); p++) begin
      logic [NI-1:0] w;
      int wi;
      w = exp_winner(NI'(p));
      wi = 0;
      for (int i = 0; i < NI; i++) if (w[i]) wi = i;
      ini_valid = NI'(p);
      chk("R2 no grant before sampling", 64'(ini_ready), 64'(0));
      @(negedge clk);
      chk("R3 R4 winner", 64'(ini_ready), 64'(w));
      chk("R6 tgt_valid", 64'(tgt_valid), 64'(1));
      chk("R6 tgt_addr", 64'(tgt_addr), 64'(addr_of(wi)));
      chk("R6 tgt_wdata", 64'(tgt_wdata), 64'(ini_wdata[DW*wi +: DW]));
      ini_valid = '0;
      tgt_ack = NT'(1 << (p % NT));
      @(negedge clk);
      chk("R7 rsp target", 64'(ini_rsp_valid), 64'(w));
      chk("R7 rsp data", 64'(ini_rsp_data), 64'(rd_of(p % NT)));
      chk("R6 idle", 64'(tgt_valid), 64'(0));
      tgt_ack = '0;
      @(negedge clk);
    end

    // queue drains one per clock while held: R5
    ini_valid = '1;
    for (int k = 0; k < NI; k++) begin
      logic [NI-1:0] w;
      w = exp_winner(ini_valid);
      @(negedge clk);
      chk("R5 drain order", 64'(ini_ready), 64'(w));
      ini_valid = ini_valid & ~ini_ready;
    end
    @(negedge clk);
    @(negedge clk);

    // persistent high-priority request alternates with CPU: R5
    ini_valid = NI'(5'b00101);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R5 alternate", 64'(ini_ready), (k % 2 == 0) ? 64'(5'b00100) : 64'(5'b00001));
    end
    ini_valid = '0;
    @(negedge clk);
    @(negedge clk);

    // response selection sweep, with and without identification flag: R7 R8 R9
    for (int w = 0; w < 2; w++) begin
      for (int a = 0; a < (1 << NT); a++) begin
        logic [NT-1:0] elig;
        int pick;
        elig = NT'(a);
        if (w == 1) elig[1:0] = 2'b00;
        pick = -1;
        for (int b = 0; b < NB; b++) if (pick < 0 && elig[2+b]) pick = 2 + b;
        if (pick < 0 && elig[1]) pick = 1;
        if (pick < 0 && elig[0]) pick = 0;
        ini_addr[AW*1 +: AW] = addr_of(1);
        ini_addr[AW*1 + WRU_BIT] = w[0];
        ini_valid = NI'(2);
        @(negedge clk);
        ini_valid = '0;
        tgt_ack = NT'(a);
        @(negedge clk);
        tgt_ack = '0;
        if (pick < 0) begin
          chk(w ? "R9 R8 wru nak" : "R8 nak flag", 64'(ini_rsp_nak), 64'(1));
          chk(w ? "R9 R8 wru zero" : "R8 zero data", 64'(ini_rsp_data), 64'(0));
        end else begin
          chk(w ? "R9 wru ack" : "R7 ack", 64'(ini_rsp_nak), 64'(0));
          chk(w ? "R9 wru data" : "R7 data", 64'(ini_rsp_data), 64'(rd_of(pick)));
        end
        chk("R7 rsp to console", 64'(ini_rsp_valid), 64'(2));
      end
    end
    ini_addr[AW*1 +: AW] = addr_of(1);

    // interrupt merge: R10
    for (int b = 0; b < NB; b++)
      for (int l = 0; l < NL; l++) begin
        br_irq = '0;
        br_irq[NL*b + l] = 1'b1;
        #1;
        chk("R10 single level", 64'(cpu_irq), 64'(1 << l));
      end
    begin
      logic [31:0] s;
      s = 32'h1234_5678;
      for (int k = 0; k < 64; k++) begin
        logic [NL-1:0] e;
        s = s * 32'd1103515245 + 32'd12345;
        br_irq = (NB*NL)'(s >> 5);
        e = '0;
        for (int b = 0; b < NB; b++) e = e | br_irq[NL*b +: NL];
        #1;
        chk("R10 merged", 64'(cpu_irq), 64'(e));
      end
    end
    br_irq = '0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule